// File: doc/BRIEF.md
# Rotary-Encoder Tuned Decimal Frequency Register

This block turns the two quadrature outputs of a mechanical rotary shaft encoder into a tuning count held as packed BCD digits. Each count step stands for 100 Hz of synthesizer output, and the default limits span 10 kHz (100 steps) to 60 MHz (600000 steps). The raw A and B contacts are synchronised and filtered. A sequential decoder then tracks the encoder through its four Gray-code states. It issues one up strobe or one down strobe per complete detent cycle, never both at once.

The strobes step a ripple chain of decimal up/down digits. The chain clamps at a lower and an upper limit instead of wrapping. Behind the count, a digit-by-digit decimal adder adds a static calibration offset and produces the divide value for a downstream programmable divider. That value has one extra digit to hold the final carry.

Top module: `encoder_bcd_tuner`

## Requirements
- R1: A level change on enc_a or enc_b is accepted only once it has held for FILT_LEN consecutive clocks after the two-stage synchroniser. A pulse of one or two clocks has no effect on count_bcd.
- R2: With the encoder state written {A,B}, the order 00→10→11→01→00 (A leading B) raises the count by one step. The order 00→01→11→10→00 (B leading A) lowers it by one step.
- R3: Exactly one step results per complete four-transition cycle, issued on the return to state 00. A partial cycle that reverses back to 00 leaves the count unchanged.
- R4: Up and down strobes never occur in the same clock, so count_bcd changes by at most one step per clock.
- R5: Each nibble of count_bcd (nibble 0 is the least significant decimal digit) stays in 0..9. Counting up from 9 gives 0 and carries into the next digit; counting down from 0 gives 9 and borrows from the next digit.
- R6: An up step at MAX_STEPS leaves the count at MAX_STEPS.
- R7: Reset loads MIN_STEPS. A down step at MIN_STEPS leaves the count at MIN_STEPS, and the count never leaves the range MIN_STEPS..MAX_STEPS.
- R8: modulus_bcd equals the decimal sum of count_bcd and offset_bcd (both packed BCD, nibble 0 least significant), with DIGITS+1 digits. The top digit is the final carry, either 0 or 1.
- R9: A transition in which A and B change together (00↔11 or 10↔01) is ignored and does not advance the cycle tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder contact A, asynchronous |
| enc_b | input | 1 | Encoder contact B, asynchronous |
| offset_bcd | input | 4*DIGITS | Calibration offset, packed BCD, static |
| count_bcd | output | 4*DIGITS | Tuning count, packed BCD |
| modulus_bcd | output | 4*(DIGITS+1) | Count plus offset, packed BCD, divider modulus |

## Verification
The hardest case to reach from the ports is a chain of carries or borrows through several digits, together with the clamp limits. Getting there takes many complete quadrature cycles, and each cycle costs four filtered transitions. The bench therefore uses three digits and a maximum of 120. It walks the count from the minimum through 9→10, 99→100 and up into the upper clamp, then back down across 100→99. The offset is switched to 999 so that the modulus carries into its extra digit. Short glitches, reversed half-cycles and diagonal jumps are placed between full cycles, and a per-clock behavioural model must still agree with the design at every step.

// File: rtl/encoder_bcd_pkg.sv
package encoder_bcd_pkg;

  // Add two BCD digits plus carry; result {carry, digit}.
  function automatic logic [4:0] bcd_add_digit(input logic [3:0] a, input logic [3:0] b,
                                              input logic cin);
    logic [4:0] s;
    s = {1'b0, a} + {1'b0, b} + {4'b0, cin};
    if (s > 5'd9) s = s + 5'd6;
    return s;
  endfunction

  // Position of a {A,B} state along the forward rotation order.
  function automatic logic [1:0] quad_index(input logic [1:0] ab);
    case (ab)
      2'b00:   return 2'd0;
      2'b10:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/encoder_input_filter.sv
module encoder_input_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic clean_out
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic         sync1, sync2;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      run_cnt   <= '0;
      clean_out <= 1'b0;
    end else begin
      sync1 <= raw_in;
      sync2 <= sync1;
      if (sync2 == clean_out) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(FILT_LEN - 1)) begin
        clean_out <= sync2;
        run_cnt   <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R1: the filtered level only ever moves to the synchroniser's value
  assert_filter_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean_out) |-> clean_out == $past(sync2));

endmodule

// File: rtl/encoder_quad_decoder.sv
module encoder_quad_decoder
  import encoder_bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab_clean,
  output logic       up_stb,
  output logic       dn_stb
);
  logic [1:0]        prev_ab;
  logic signed [2:0] phase_acc;
  logic [1:0]        idx_diff;
  logic              step_fwd, step_bwd;

  assign idx_diff = quad_index(ab_clean) - quad_index(prev_ab);
  assign step_fwd = (idx_diff == 2'd1);
  assign step_bwd = (idx_diff == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ab   <= 2'b00;
      phase_acc <= '0;
      up_stb    <= 1'b0;
      dn_stb    <= 1'b0;
    end else begin
      prev_ab <= ab_clean;
      up_stb  <= 1'b0;
      dn_stb  <= 1'b0;
      if (step_fwd) begin
        if (phase_acc == 3'sd3) begin
          up_stb    <= 1'b1;
          phase_acc <= '0;
        end else begin
          phase_acc <= phase_acc + 3'sd1;
        end
      end else if (step_bwd) begin
        if (phase_acc == -3'sd3) begin
          dn_stb    <= 1'b1;
          phase_acc <= '0;
        end else begin
          phase_acc <= phase_acc - 3'sd1;
        end
      end
    end
  end

  // R4: strobes are mutually exclusive
  assert_excl_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_stb && dn_stb));

  // R3: a strobe only follows arrival at the detent state 00
  assert_detent_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_stb || dn_stb) |-> $past(ab_clean) == 2'b00);

  // R9: a diagonal jump never produces a strobe in the next cycle
  assert_diag_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_diff == 2'd2) |=> !(up_stb || dn_stb));

endmodule

// File: rtl/encoder_bcd_counter.sv
module encoder_bcd_counter #(
  parameter int DIGITS    = 6,
  parameter int MIN_STEPS = 100,
  parameter int MAX_STEPS = 600000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  up_stb,
  input  logic                  dn_stb,
  output logic [4*DIGITS-1:0]   count_bcd
);
  localparam int CW = 4 * DIGITS;

  function automatic logic [CW-1:0] int_to_bcd(input int v);
    logic [CW-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  localparam logic [CW-1:0] MIN_BCD = int_to_bcd(MIN_STEPS);
  localparam logic [CW-1:0] MAX_BCD = int_to_bcd(MAX_STEPS);

  logic [3:0]        dig [DIGITS];
  logic [DIGITS-1:0] inc, dec;
  logic              at_max, at_min;

  assign at_max = (count_bcd == MAX_BCD);
  assign at_min = (count_bcd == MIN_BCD);
  assign inc[0] = up_stb && !at_max;
  assign dec[0] = dn_stb && !at_min;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    assign count_bcd[4*i +: 4] = dig[i];
    if (i < DIGITS - 1) begin : g_ripple
      assign inc[i+1] = inc[i] && (dig[i] == 4'd9);
      assign dec[i+1] = dec[i] && (dig[i] == 4'd0);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dig[i] <= MIN_BCD[4*i +: 4];
      else if (inc[i]) dig[i] <= (dig[i] == 4'd9) ? 4'd0 : dig[i] + 4'd1;
      else if (dec[i]) dig[i] <= (dig[i] == 4'd0) ? 4'd9 : dig[i] - 4'd1;
    end
    // R5: every digit stays a decimal digit
    assert_digit_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dig[i] <= 4'd9);
  end

  // R6: an up step at the ceiling leaves the count alone
  assert_hold_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_bcd == MAX_BCD && up_stb) |=> $stable(count_bcd));
  // R7: a down step at the floor leaves the count alone
  assert_hold_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_bcd == MIN_BCD && dn_stb) |=> $stable(count_bcd));
  // R7: packed BCD orders like the number it encodes
  assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_bcd >= MIN_BCD && count_bcd <= MAX_BCD);

endmodule

// File: rtl/encoder_offset_adder.sv
module encoder_offset_adder
  import encoder_bcd_pkg::*;
#(
  parameter int DIGITS = 6
) (
  input  logic [4*DIGITS-1:0]     a_bcd,
  input  logic [4*DIGITS-1:0]     b_bcd,
  output logic [4*(DIGITS+1)-1:0] sum_bcd
);
  logic [DIGITS:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_add
    logic [4:0] part;
    assign part = bcd_add_digit(a_bcd[4*i +: 4], b_bcd[4*i +: 4], carry[i]);
    assign sum_bcd[4*i +: 4] = part[3:0];
    assign carry[i+1] = part[4];
  end

  assign sum_bcd[4*DIGITS +: 4] = {3'b000, carry[DIGITS]};

endmodule

// File: rtl/encoder_bcd_tuner.sv
module encoder_bcd_tuner #(
  parameter int DIGITS    = 6,
  parameter int FILT_LEN  = 4,
  parameter int MIN_STEPS = 100,
  parameter int MAX_STEPS = 600000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enc_a,
  input  logic                     enc_b,
  input  logic [4*DIGITS-1:0]      offset_bcd,
  output logic [4*DIGITS-1:0]      count_bcd,
  output logic [4*(DIGITS+1)-1:0]  modulus_bcd
);
  logic [1:0] raw_ab, clean_ab;
  logic       up_stb, dn_stb;

  assign raw_ab = {enc_a, enc_b};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    encoder_input_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (raw_ab[ch]),
      .clean_out(clean_ab[ch])
    );
  end

  encoder_quad_decoder u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ab_clean(clean_ab),
    .up_stb  (up_stb),
    .dn_stb  (dn_stb)
  );

  encoder_bcd_counter #(
    .DIGITS(DIGITS), .MIN_STEPS(MIN_STEPS), .MAX_STEPS(MAX_STEPS)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_stb   (up_stb),
    .dn_stb   (dn_stb),
    .count_bcd(count_bcd)
  );

  encoder_offset_adder #(.DIGITS(DIGITS)) u_add (
    .a_bcd  (count_bcd),
    .b_bcd  (offset_bcd),
    .sum_bcd(modulus_bcd)
  );

  // R8: the extra modulus digit only ever holds a carry
  assert_mod_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    modulus_bcd[4*DIGITS +: 4] <= 4'd1);

endmodule

// File: tb/test_encoder_bcd_tuner.sv
module test_encoder_bcd_tuner;
  localparam int DIGITS = 3;
  localparam int FL     = 4;
  localparam int MINS   = 7;
  localparam int MAXS   = 120;
  localparam int HOLD   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ea = 1'b0, eb = 1'b0;
  logic [4*DIGITS-1:0]     offset = 12'h358;
  logic [4*DIGITS-1:0]     count_bcd;
  logic [4*(DIGITS+1)-1:0] modulus_bcd;

  int checks = 0, fails = 0, cycles = 0, last_count = MINS;
  bit done = 0;

  always #2 clk = ~clk;

  encoder_bcd_tuner #(.DIGITS(DIGITS), .FILT_LEN(FL), .MIN_STEPS(MINS), .MAX_STEPS(MAXS))
    i_encoder_bcd_tuner (.clk(clk), .rst_n(rst_n), .enc_a(ea), .enc_b(eb),
      .offset_bcd(offset), .count_bcd(count_bcd), .modulus_bcd(modulus_bcd));

  function automatic int bcd2int(input logic [31:0] v, input int nd);
    int r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic int rot_pos(input bit [1:0] ab);
    int p;
    p = (ab == 2'b00) ? 0 : (ab == 2'b10) ? 1 : (ab == 2'b11) ? 2 : 3;
    return p;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced once per rising edge.
  bit [1:0] m_s1, m_s2, m_filt, m_prev;
  int m_run[2], m_acc, m_count;
  bit m_up, m_dn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_prev = 0; m_run[0] = 0; m_run[1] = 0;
      m_acc = 0; m_up = 0; m_dn = 0; m_count = MINS;
    end else begin
      if (m_up && m_count < MAXS) m_count++;
      else if (m_dn && m_count > MINS) m_count--;
      m_up = 0; m_dn = 0;
      case ((rot_pos(m_filt) - rot_pos(m_prev) + 4) % 4)
        1: if (m_acc == 3) begin m_up = 1; m_acc = 0; end else m_acc++;
        3: if (m_acc == -3) begin m_dn = 1; m_acc = 0; end else m_acc--;
        default: ;
      endcase
      m_prev = m_filt;
      for (int ch = 0; ch < 2; ch++) begin
        if (m_s2[ch] == m_filt[ch]) m_run[ch] = 0;
        else if (m_run[ch] == FL - 1) begin m_filt[ch] = m_s2[ch]; m_run[ch] = 0; end
        else m_run[ch]++;
      end
      m_s2 = m_s1;
      m_s1 = {ea, eb};
    end
  end

  // Per-clock comparison, sampled mid-period.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int c;
      c = bcd2int(32'(count_bcd), DIGITS);
      check("R2 R5 count vs model", c, m_count);
      check("R8 modulus vs model", bcd2int(32'(modulus_bcd), DIGITS + 1),
            m_count + bcd2int(32'(offset), DIGITS));
      check("R4 at most one step per clock", (c - last_count) * (c - last_count) <= 1, 1);
      last_count = c;
    end
  end

  task automatic drive(input bit [1:0] v, input int n);
    @(posedge clk); #1;
    ea = v[1]; eb = v[0];
    repeat (n) @(posedge clk);
  endtask

  task automatic turn_up(input int n);
    for (int k = 0; k < n; k++) begin
      drive(2'b10, HOLD); drive(2'b11, HOLD); drive(2'b01, HOLD); drive(2'b00, HOLD);
    end
  endtask

  task automatic turn_down(input int n);
    for (int k = 0; k < n; k++) begin
      drive(2'b01, HOLD); drive(2'b11, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
    end
  endtask

  task automatic expect_count(input string tag, input int exp);
    @(negedge clk);
    check(tag, bcd2int(32'(count_bcd), DIGITS), exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_count("R7 reset value", MINS);
    check("R8 reset modulus 7+358", bcd2int(32'(modulus_bcd), DIGITS + 1), 365);
    turn_down(2);
    expect_count("R7 floor clamp", MINS);
    turn_up(3);
    expect_count("R2 R5 carry 9->10", 10);
    drive(2'b10, 1); drive(2'b00, HOLD + 4);
    expect_count("R1 short glitch ignored", 10);
    drive(2'b10, HOLD); drive(2'b11, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
    expect_count("R3 reversed partial cycle", 10);
    drive(2'b11, HOLD); drive(2'b00, HOLD);
    expect_count("R9 diagonal jump ignored", 10);
    turn_down(1);
    expect_count("R2 R5 borrow 10->9", 9);
    turn_up(91);
    expect_count("R5 two-digit carry to 100", 100);
    @(posedge clk); #1 offset = 12'h999;
    @(negedge clk);
    check("R8 modulus carry digit 100+999", bcd2int(32'(modulus_bcd), DIGITS + 1), 1099);
    check("R8 top modulus digit", int'(modulus_bcd[4*DIGITS +: 4]), 1);
    turn_up(25);
    expect_count("R6 ceiling clamp", MAXS);
    turn_down(21);
    expect_count("R5 borrow 100->99", 99);
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule